// File: doc/BRIEF.md
# Pipelined CORDIC Phase Rotator

This block turns a complex sample I + jQ through a requested angle with nothing but arithmetic shifts and additions. The rotation is split into a fixed chain of circular-mode CORDIC micro-rotations, and each one sits in its own pipeline register. A new sample can enter on every clock, and each result leaves a fixed number of clocks later. The usual place for it is a receiver front end, where it applies a phase offset or a mixing step to a stream of baseband samples.

The angle is a signed binary fraction of a full turn, so every angle can be expressed. The micro-rotations on their own only reach a little past ±90°. When a request lies further out, the block subtracts half a turn from the angle at the input and records that in a per-sample flag. A pass-or-negate step after the last iteration then flips the sign of the result for that sample. The CORDIC gain (about 1.647) stays in the outputs. A scaling multiply is left to later processing, and the output words carry two guard bits so that this growth cannot overflow.

Top module: `cordic_rotator`

## Requirements
- R1: Iteration k uses the angle constant round(atan(2^-k) · 2^PHASE_W / 2π). For 16-bit angles the first eight constants are 8192, 4836, 2555, 1297, 651, 326, 163 and 81.
- R2: An input angle is folded when its two top bits differ, that is, when it lies at or beyond +90° (0x4000..0x7FFF) or below −90° (0x8000..0xBFFF). Folding inverts the angle's top bit, which subtracts 180°. For a folded sample, both outputs are negated after the last iteration.
- R3: In iteration k, with x and y as the running I and Q values and z as the residual angle, a residual of zero or more gives x − (y>>>k), y + (x>>>k) and z − θk. A negative residual gives x + (y>>>k), y − (x>>>k) and z + θk. The shifts are arithmetic.
- R4: A sample presented with in_valid high appears on the outputs exactly STAGES clocks later (8 by default). Samples may be presented on every clock, with or without gaps.
- R5: out_valid is in_valid delayed by STAGES clocks. A synchronous active-high reset clears every valid bit in flight, so out_valid is low on the clock after reset is sampled.
- R6: The outputs are DATA_W+2 bits wide and carry the uncompensated gain of about 1.647. Full-scale inputs, including −32768 on both I and Q, produce results that do not wrap.
- R7: For any input, the result is within 0.015·|I+jQ| + 16 LSB of 1.64676 times the exactly rotated sample.
- R8: A zero input sample yields zero on both outputs, whatever the angle.
- R9: The fold decision travels with its own sample. Back-to-back samples that alternate between folded and unfolded angles are each corrected independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears the valid pipeline |
| in_valid | input | 1 | Marks in_i, in_q and in_phase as a sample |
| in_i | input | DATA_W | Signed in-phase input |
| in_q | input | DATA_W | Signed quadrature input |
| in_phase | input | PHASE_W | Rotation angle as a signed fraction of a full turn (0x8000 = −180°) |
| out_valid | output | 1 | Marks out_i and out_q as a result |
| out_i | output | DATA_W+2 | Rotated in-phase result, including the CORDIC gain |
| out_q | output | DATA_W+2 | Rotated quadrature result, including the CORDIC gain |

## Verification
The two functions that can act in the same cycle are the output-side negation of one folded sample and the unfolded pass-through of the sample directly behind it. Both are live at once when consecutive samples straddle ±90°. The bench provokes this with dense streams of alternating folded and unfolded angles and with random angles at full throughput. It compares every result bit-exactly against a model of the iteration built from the requirement equations, and separately against floating-point rotation within the accuracy bound. A reset is also applied while the pipeline is full, to check that the clearing of in-flight valid bits does not leak a result.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    // Direction of one micro-rotation.
    typedef enum logic {
        ROT_CCW = 1'b0,   // residual >= 0: turn counter-clockwise
        ROT_CW  = 1'b1    // residual <  0: turn clockwise
    } rot_dir_e;

    localparam int unsigned TABLE_FRAC = 24;   // table precision in bits per turn
    localparam int unsigned TABLE_LEN  = 16;   // supported iteration count

    // atan(2^-k) in units of 2^-24 of a full turn (R1).
    function automatic int atan_q24(input int idx);
        case (idx)
            0:  return 2097152;
            1:  return 1238021;
            2:  return 654136;
            3:  return 332050;
            4:  return 166669;
            5:  return 83416;
            6:  return 41718;
            7:  return 20860;
            8:  return 10430;
            9:  return 5215;
            10: return 2608;
            11: return 1304;
            12: return 652;
            13: return 326;
            14: return 163;
            15: return 81;
            default: return 0;
        endcase
    endfunction

    // Rounded to the angle width used by the datapath.
    function automatic int atan_scaled(input int idx, input int pw);
        int raw;
        int sh;
        raw = atan_q24(idx);
        sh  = int'(TABLE_FRAC) - pw;
        if (sh <= 0) return raw;
        return (raw + (1 << (sh - 1))) >>> sh;
    endfunction

    // Angle needs a half-turn fold when its two top bits differ (R2).
    function automatic logic needs_fold(input logic top, input logic next);
        return top ^ next;
    endfunction

endpackage

// File: rtl/cordic_rot_fold.sv
module cordic_rot_fold
    import cordic_rot_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PHASE_W = 16,
    parameter int W       = DATA_W + 2
) (
    input  logic signed [DATA_W-1:0]  in_i,
    input  logic signed [DATA_W-1:0]  in_q,
    input  logic        [PHASE_W-1:0] in_phase,
    output logic signed [W-1:0]       out_x,
    output logic signed [W-1:0]       out_y,
    output logic signed [PHASE_W-1:0] out_z,
    output logic                      out_fold
);
    localparam int EXT = W - DATA_W;

    logic fold;

    always_comb begin
        fold     = needs_fold(in_phase[PHASE_W-1], in_phase[PHASE_W-2]);
        out_fold = fold;
        out_x    = {{EXT{in_i[DATA_W-1]}}, in_i};
        out_y    = {{EXT{in_q[DATA_W-1]}}, in_q};
        // Subtracting a half turn in a binary angle is an MSB inversion.
        out_z    = {in_phase[PHASE_W-1] ^ fold, in_phase[PHASE_W-2:0]};
    end

endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage
    import cordic_rot_pkg::*;
#(
    parameter int W       = 18,
    parameter int PHASE_W = 16,
    parameter int IDX     = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic                      in_fold,
    input  logic signed [W-1:0]       in_x,
    input  logic signed [W-1:0]       in_y,
    input  logic signed [PHASE_W-1:0] in_z,
    output logic                      out_vld,
    output logic                      out_fold,
    output logic signed [W-1:0]       out_x,
    output logic signed [W-1:0]       out_y,
    output logic signed [PHASE_W-1:0] out_z
);
    localparam logic signed [PHASE_W-1:0] THETA = PHASE_W'(atan_scaled(IDX, PHASE_W));

    rot_dir_e                  dir;
    logic signed [W-1:0]       xs, ys, nx, ny;
    logic signed [PHASE_W-1:0] nz;

    always_comb begin
        dir = in_z[PHASE_W-1] ? ROT_CW : ROT_CCW;
        xs  = in_x >>> IDX;
        ys  = in_y >>> IDX;
        case (dir)
            ROT_CCW: begin
                nx = in_x - ys;
                ny = in_y + xs;
                nz = in_z - THETA;
            end
            default: begin
                nx = in_x + ys;
                ny = in_y - xs;
                nz = in_z + THETA;
            end
        endcase
    end

    // Valid bit: the only state that reset touches.
    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= in_vld;
    end

    // Data path runs freely; its contents only matter under valid.
    always_ff @(posedge clk) begin
        out_x    <= nx;
        out_y    <= ny;
        out_z    <= nz;
        out_fold <= in_fold;
    end

endmodule

// File: rtl/cordic_rot_unfold.sv
module cordic_rot_unfold #(
    parameter int W = 18
) (
    input  logic              fold,
    input  logic signed [W-1:0] in_x,
    input  logic signed [W-1:0] in_y,
    output logic signed [W-1:0] out_x,
    output logic signed [W-1:0] out_y
);
    always_comb begin
        if (fold) begin
            out_x = -in_x;
            out_y = -in_y;
        end else begin
            out_x = in_x;
            out_y = in_y;
        end
    end

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
    import cordic_rot_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PHASE_W = 16,
    parameter int STAGES  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [PHASE_W-1:0]       in_phase,
    output logic                     out_valid,
    output logic signed [DATA_W+1:0] out_i,
    output logic signed [DATA_W+1:0] out_q
);
    localparam int W = DATA_W + 2;   // two guard bits for gain and diagonal growth

    logic                      vld  [STAGES+1];
    logic                      fold [STAGES+1];
    logic signed [W-1:0]       x    [STAGES+1];
    logic signed [W-1:0]       y    [STAGES+1];
    logic signed [PHASE_W-1:0] z    [STAGES+1];

    assign vld[0] = in_valid;

    cordic_rot_fold #(
        .DATA_W  (DATA_W),
        .PHASE_W (PHASE_W),
        .W       (W)
    ) u_fold (
        .in_i     (in_i),
        .in_q     (in_q),
        .in_phase (in_phase),
        .out_x    (x[0]),
        .out_y    (y[0]),
        .out_z    (z[0]),
        .out_fold (fold[0])
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_iter
        cordic_rot_stage #(
            .W       (W),
            .PHASE_W (PHASE_W),
            .IDX     (k)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (vld[k]),
            .in_fold  (fold[k]),
            .in_x     (x[k]),
            .in_y     (y[k]),
            .in_z     (z[k]),
            .out_vld  (vld[k+1]),
            .out_fold (fold[k+1]),
            .out_x    (x[k+1]),
            .out_y    (y[k+1]),
            .out_z    (z[k+1])
        );
    end

    // Final residual angle is the rotation error; not needed downstream.
    logic unused_resid;
    assign unused_resid = ^z[STAGES];

    cordic_rot_unfold #(
        .W (W)
    ) u_unfold (
        .fold  (fold[STAGES]),
        .in_x  (x[STAGES]),
        .in_y  (y[STAGES]),
        .out_x (out_i),
        .out_y (out_q)
    );

    assign out_valid = vld[STAGES];

endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
    parameter int DATA_W = 16,
    parameter int STAGES = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_i,
    input logic signed [DATA_W-1:0] in_q,
    input logic                     out_valid,
    input logic signed [DATA_W+1:0] out_i,
    input logic signed [DATA_W+1:0] out_q
);
    logic [STAGES-1:0] vh;
    logic [STAGES-1:0] zh;
    longint            eh [STAGES];
    longint            ie, oe;

    always_comb begin
        ie = longint'(in_i) * longint'(in_i) + longint'(in_q) * longint'(in_q);
        oe = longint'(out_i) * longint'(out_i) + longint'(out_q) * longint'(out_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vh <= '0;
            zh <= '0;
        end else begin
            vh <= {vh[STAGES-2:0], in_valid};
            zh <= {zh[STAGES-2:0], in_valid && in_i == '0 && in_q == '0};
        end
    end

    always_ff @(posedge clk) begin
        eh[0] <= ie;
        for (int k = 1; k < STAGES; k++) eh[k] <= eh[k-1];
    end

    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vh[STAGES-1]);

    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_zero_in_zero_out_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zh[STAGES-1]) |-> (out_i == '0 && out_q == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (oe <= 3 * eh[STAGES-1] + 64'd4096));

    assert_gain_floor_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (2 * oe + 64'd8388608 >= 5 * eh[STAGES-1]));

endmodule

bind cordic_rotator cordic_rotator_chk #(
    .DATA_W (DATA_W),
    .STAGES (STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/cordic_rotator_test.sv
`timescale 1ns/1ps
module cordic_rotator_test;
    localparam int    NS = 8;
    localparam real   PI = 3.14159265358979;
    localparam real   KG = 1.64676;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [15:0]        in_phase = '0;
    logic               out_valid;
    logic signed [17:0] out_i, out_q;

    always #2.5 clk = ~clk;

    cordic_rotator uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_phase(in_phase), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    typedef struct {
        bit    v;
        bit    acc;
        int    i, q, ph, ex, ey;
        string tag;
    } exp_t;

    exp_t hist [16];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 0;
    int unsigned seed = 32'h5EED;

    // R1: angle constant of iteration s.
    function automatic int theta(input int s);
        return $rtoi($atan(2.0 ** (-s)) * 65536.0 / (2.0 * PI) + 0.5);
    endfunction

    // R2 fold, R3 iterations, R2 output negation.
    function automatic void model(input int i, input int q, input int ph,
                                  output int ox, output int oy);
        int x, y, z, nx, ny;
        bit f;
        x = i; y = q;
        z = (ph >= 32768) ? ph - 65536 : ph;
        f = (z >= 16384) || (z < -16384);
        if (f) z = (z >= 0) ? z - 32768 : z + 32768;
        for (int s = 0; s < NS; s++) begin
            if (z >= 0) begin
                nx = x - (y >>> s); ny = y + (x >>> s); z = z - theta(s);
            end else begin
                nx = x + (y >>> s); ny = y - (x >>> s); z = z + theta(s);
            end
            x = nx; y = ny;
        end
        ox = f ? -x : x;
        oy = f ? -y : y;
    endfunction

    task automatic fail_line(input string tag, input string what, input int got, input int expv);
        fails++;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    endtask

    task automatic check_out(input string vtag);
        exp_t e;
        int   gi, gq;
        real  phi, ix, iy, mag, tol, err;
        e = hist[(cyc - NS) & 15];
        checks++;
        if (out_valid !== e.v) fail_line(vtag, "out_valid", int'(out_valid), int'(e.v));
        if (e.v && out_valid === 1'b1) begin
            gi = int'(out_i);
            gq = int'(out_q);
            checks++;
            if (gi != e.ex || gq != e.ey) begin
                fail_line(e.tag, "out_i", gi, e.ex);
                $display("FAIL %s out_q: got %0d expected %0d", e.tag, gq, e.ey);
            end
            if (e.acc) begin
                checks++;
                phi = real'((e.ph >= 32768) ? e.ph - 65536 : e.ph) * 2.0 * PI / 65536.0;
                ix  = KG * (real'(e.i) * $cos(phi) - real'(e.q) * $sin(phi));
                iy  = KG * (real'(e.i) * $sin(phi) + real'(e.q) * $cos(phi));
                mag = $sqrt(real'(e.i) * real'(e.i) + real'(e.q) * real'(e.q));
                tol = 0.015 * mag + 16.0;
                err = (ix > real'(gi)) ? ix - real'(gi) : real'(gi) - ix;
                if (((iy > real'(gq)) ? iy - real'(gq) : real'(gq) - iy) > err)
                    err = (iy > real'(gq)) ? iy - real'(gq) : real'(gq) - iy;
                if (err > tol) fail_line("R7", "error LSB", $rtoi(err), $rtoi(tol));
            end
        end
    endtask

    task automatic drive(input bit v, input int i, input int q, input int ph,
                         input string tag, input bit acc);
        int ex, ey;
        @(negedge clk);
        check_out("R4");
        rst = 1'b0;
        model(i, q, ph, ex, ey);
        hist[cyc & 15] = '{v: v, acc: acc && v, i: i, q: q, ph: ph, ex: ex, ey: ey, tag: tag};
        in_valid = v;
        in_i     = 16'(i);
        in_q     = 16'(q);
        in_phase = 16'(ph);
        cyc++;
    endtask

    task automatic reset_pulse(input int n);
        repeat (n) begin
            @(negedge clk);
            check_out("R5");
            rst = 1'b1;
            for (int k = 0; k < 16; k++) hist[k].v = 1'b0;
            in_valid = 1'b0;
            cyc++;
        end
    endtask

    initial begin
        int ph_list [6] = '{32'h8000, 32'h4000, 32'hC000, 32'h3FFF, 32'hBFFF, 32'h7FFF};
        int corner  [2] = '{32767, -32768};
        for (int k = 0; k < 16; k++) hist[k] = '{v: 0, acc: 0, i: 0, q: 0, ph: 0, ex: 0, ey: 0, tag: "R4"};
        void'($urandom(seed));

        reset_pulse(4);

        drive(1, 16384, 0, 0, "R1", 1);
        drive(1, 0, 16384, 16'h1000, "R1", 1);
        drive(1, 0, 0, 16'h1234, "R8", 0);
        drive(1, 0, 0, 16'h8000, "R8", 0);
        foreach (ph_list[k]) drive(1, 12000, -5000, ph_list[k], "R2", 1);
        foreach (corner[a]) foreach (corner[b])
            for (int p = 0; p < 4; p++)
                drive(1, corner[a], corner[b], 16'h2000 + p * 16'h4000, "R6", 1);
        for (int k = 0; k < 16; k++)
            drive(1, 20000 - k * 900, 7000 + k * 300, (k % 2) ? 16'h9000 : 16'h1000, "R9", 1);
        drive(1, 3000, 4000, 16'h0800, "R4", 1);
        repeat (3) drive(0, 111, 222, 16'h0333, "R4", 0);
        drive(1, -3000, 4000, 16'hF800, "R4", 1);
        for (int k = 0; k < 20; k++) drive(0, 0, 0, 0, "R4", 0);

        for (int n = 0; n < 3000; n++)
            drive(($urandom % 5) != 0, int'($urandom % 65536) - 32768,
                  int'($urandom % 65536) - 32768, int'($urandom % 65536), "R3", 1);

        for (int k = 0; k < 6; k++) drive(1, 5000 + k, -6000, 16'h6000, "R5", 1);
        reset_pulse(2);
        for (int k = 0; k < 10; k++) drive(1, -7000, 9000 - k, 16'hA000, "R5", 1);
        for (int k = 0; k < 12; k++) drive(0, 0, 0, 0, "R4", 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", 200000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule